// File: doc/BRIEF.md
# Chained LED driver packet transmitter

This block sits on the controller side of a daisy chain of PWM LED driver devices. Each device holds a 224-bit shift register, and all devices latch their data together once the shift clock has stayed idle for long enough. The transmitter takes one 224-bit packet per device from a valid/ready stream and serializes the whole frame on a shift clock and a data line. Packets follow each other with no gap, in the order they are accepted. The caller therefore supplies the packet for the most distant device first and the nearest device last. The top six bits of every packet are overwritten with the write command that the devices require before they will latch.

A frame begins with a start pulse while the block is ready. The device count and the half-period divisor are captured at that point. Data changes only while the clock is low, so it is stable around every rising edge. After the last bit the clock stays low for nine bit periods, which exceeds the eight-period latch trigger. A programmable recovery delay then runs before ready returns. If the packet stream runs dry in the middle of a frame, the clock is held low until the next packet arrives. Such a stall may look like a latch trigger to the devices, so the block raises an error flag for that frame.

Top module: `ledchain_tx`

## Requirements
- R1: After reset, ready_o is 1 and sclk_o, sdat_o, pkt_ready_o and stall_err_o are all 0.
- R2: A start accepted with device count N (N from 1 to 2^CNT_W-1) yields exactly 224×N rising edges of sclk_o. A start with a device count of 0 is ignored, and ready_o stays 1.
- R3: Bits are sent most significant bit first, one bit per rising edge. Packets are sent in the order they were accepted. The value of sdat_o at each rising edge equals the corresponding packet bit.
- R4: Packet bits 223 down to 218 are always transmitted as 1,0,0,1,0,1 (the write command 6'b100101), whatever the input holds there. All other bits pass through unchanged.
- R5: Each high half and each low half of sclk_o inside a packet lasts H system cycles, where H = max(half_div_i, 2) captured at start. sdat_o never changes while sclk_o is high.
- R6: When the next packet has been accepted before the current packet ends, the low half between the two packets is exactly H cycles, so the packets run back to back.
- R7: After the last rising edge of a frame, sclk_o stays low. ready_o rises 19×H + RECOV_CYC system cycles after that edge: H for the final high half, 18×H for the nine-bit-period idle gap, and RECOV_CYC for the recovery delay.
- R8: ready_o falls in the cycle after an accepted start. While ready_o is 0, start_i, dev_count_i and half_div_i are ignored.
- R9: pkt_ready_o is 1 only while the current frame still needs packets and the one-packet holding buffer is empty. Exactly N packets are taken per frame.
- R10: A packet underflow in the middle of a frame holds sclk_o low until data arrives. It then resumes with no bits lost and sets stall_err_o to 1. stall_err_o stays 1 until the next accepted start clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Frame start request, accepted while ready_o is 1 |
| ready_o | output | 1 | Idle and able to accept a start |
| dev_count_i | input | CNT_W | Number of devices N in the chain |
| half_div_i | input | DIV_W | System cycles per shift clock half period (values below 2 act as 2) |
| pkt_data_i | input | PKT_W | Packet for the next device, most significant bit sent first |
| pkt_valid_i | input | 1 | pkt_data_i holds a packet |
| pkt_ready_o | output | 1 | The block takes the packet on this cycle when pkt_valid_i is 1 |
| sclk_o | output | 1 | Shift clock to the chain, idles low |
| sdat_o | output | 1 | Serial data to the chain, changes while the clock is low |
| stall_err_o | output | 1 | A mid-frame underflow occurred in the current or last frame |

## Verification
The hardest case to reach is a mid-frame underflow. The one-packet holding buffer fetches the next packet as soon as the current packet moves into the shift register, so a slow producer only causes a stall if it delays by more than a whole packet time. The bench withholds the second packet of a two-device frame for far longer than one packet period. It then checks that the single stretched low phase is the only deviation and that every bit still arrives in order. A separate frame checks that the flag clears. Back-to-back timing and the idle gap are confirmed by measuring every clock phase across a sweep of device counts and divisors, including divisor values below the minimum.

// File: rtl/ledchain_pkg.sv
package ledchain_pkg;
  localparam int          PKT_BITS = 224;
  localparam int          CMD_BITS = 6;
  localparam logic [5:0]  WR_CMD   = 6'b100101;

  typedef enum logic [2:0] {
    S_IDLE,
    S_FILL,
    S_SHIFT,
    S_STALL,
    S_GAP,
    S_RECOV
  } tx_state_e;
endpackage

// File: rtl/ledchain_halfclk.sv
// Half-period tick generator: one tick every half_len cycles while run is high.
module ledchain_halfclk #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [DIV_W-1:0] half_len,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;
  logic             at_end;

  assign at_end = (cnt == half_len - 1'b1);
  assign tick   = run && at_end;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt <= '0;
    end else if (at_end) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/ledchain_pktbuf.sv
// One-entry packet holding buffer; stamps the write command into the top bits.
module ledchain_pktbuf
  import ledchain_pkg::*;
#(
  parameter int PKT_W = PKT_BITS
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             want,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [PKT_W-1:0] in_data,
  input  logic             drain,
  output logic             full,
  output logic [PKT_W-1:0] out_data
);
  logic [CMD_BITS-1:0] unused_cmd_in;

  assign unused_cmd_in = in_data[PKT_W-1 -: CMD_BITS];
  assign in_ready      = want && !full;

  always_ff @(posedge clk) begin
    if (rst) begin
      full <= 1'b0;
    end else if (in_valid && in_ready) begin
      full <= 1'b1;
    end else if (drain) begin
      full <= 1'b0;
    end
  end

  // Data storage without reset so it maps onto plain registers or RAM.
  always_ff @(posedge clk) begin
    if (in_valid && in_ready) begin
      out_data <= {WR_CMD, in_data[PKT_W-CMD_BITS-1:0]};
    end
  end
endmodule

// File: rtl/ledchain_shreg.sv
// Output shift register with bit position counter.
module ledchain_shreg #(
  parameter int PKT_W  = 224,
  parameter int BCNT_W = $clog2(PKT_W)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [PKT_W-1:0] load_data,
  input  logic             shift,
  input  logic             clr,
  output logic             msb,
  output logic             last_bit
);
  logic [PKT_W-1:0]  sr;
  logic [BCNT_W-1:0] bcnt;

  assign msb      = sr[PKT_W-1];
  assign last_bit = (bcnt == BCNT_W'(PKT_W - 1));

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      sr   <= '0;
      bcnt <= '0;
    end else if (load) begin
      sr   <= load_data;
      bcnt <= '0;
    end else if (shift) begin
      sr   <= {sr[PKT_W-2:0], 1'b0};
      bcnt <= bcnt + 1'b1;
    end
  end
endmodule

// File: rtl/ledchain_tx.sv
module ledchain_tx
  import ledchain_pkg::*;
#(
  parameter int PKT_W     = PKT_BITS,
  parameter int CNT_W     = 4,
  parameter int DIV_W     = 8,
  parameter int GAP_BITS  = 9,
  parameter int RECOV_CYC = 134000
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  output logic             ready_o,
  input  logic [CNT_W-1:0] dev_count_i,
  input  logic [DIV_W-1:0] half_div_i,
  input  logic [PKT_W-1:0] pkt_data_i,
  input  logic             pkt_valid_i,
  output logic             pkt_ready_o,
  output logic             sclk_o,
  output logic             sdat_o,
  output logic             stall_err_o
);
  localparam int BCNT_W = $clog2(PKT_W);
  localparam int GCNT_W = DIV_W + $clog2(2 * GAP_BITS + 1);
  localparam int RCNT_W = $clog2(RECOV_CYC + 1);

  tx_state_e         state;
  logic [DIV_W-1:0]  half_q;
  logic [CNT_W-1:0]  pkt_left;
  logic [CNT_W-1:0]  fetch_left;
  logic              sclk_q;
  logic              err_q;
  logic [GCNT_W-1:0] gcnt;
  logic [GCNT_W-1:0] gap_lim;
  logic [RCNT_W-1:0] rcnt;

  logic              go, tick, fall, last_bit;
  logic              buf_full, want, take;
  logic              load, shift, clr;
  logic [PKT_W-1:0]  buf_data;

  assign go      = start_i && (state == S_IDLE) && (dev_count_i != '0);
  assign gap_lim = GCNT_W'(half_q) * GCNT_W'(2 * GAP_BITS);
  assign want    = ((state == S_FILL) || (state == S_SHIFT) || (state == S_STALL))
                   && (fetch_left != '0);
  assign take    = pkt_valid_i && pkt_ready_o;
  assign fall    = (state == S_SHIFT) && tick && sclk_q;
  assign shift   = fall && !last_bit;
  assign clr     = fall && last_bit && (pkt_left == '0);
  assign load    = (((state == S_FILL) || (state == S_STALL)) && buf_full)
                   || (fall && last_bit && (pkt_left != '0) && buf_full);

  ledchain_halfclk #(.DIV_W(DIV_W)) halfclk_i (
    .clk      (clk),
    .rst      (rst),
    .run      (state == S_SHIFT),
    .half_len (half_q),
    .tick     (tick)
  );

  ledchain_pktbuf #(.PKT_W(PKT_W)) pktbuf_i (
    .clk      (clk),
    .rst      (rst),
    .want     (want),
    .in_valid (pkt_valid_i),
    .in_ready (pkt_ready_o),
    .in_data  (pkt_data_i),
    .drain    (load),
    .full     (buf_full),
    .out_data (buf_data)
  );

  ledchain_shreg #(.PKT_W(PKT_W), .BCNT_W(BCNT_W)) shreg_i (
    .clk       (clk),
    .rst       (rst),
    .load      (load),
    .load_data (buf_data),
    .shift     (shift),
    .clr       (clr),
    .msb       (sdat_o),
    .last_bit  (last_bit)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= S_IDLE;
      half_q     <= DIV_W'(2);
      pkt_left   <= '0;
      fetch_left <= '0;
      sclk_q     <= 1'b0;
      err_q      <= 1'b0;
      gcnt       <= '0;
      rcnt       <= '0;
    end else begin
      unique case (state)
        S_IDLE: begin
          if (go) begin
            half_q     <= (half_div_i < DIV_W'(2)) ? DIV_W'(2) : half_div_i;
            pkt_left   <= dev_count_i;
            fetch_left <= dev_count_i;
            err_q      <= 1'b0;
            state      <= S_FILL;
          end
        end
        S_FILL, S_STALL: begin
          if (buf_full) begin
            pkt_left <= pkt_left - 1'b1;
            state    <= S_SHIFT;
          end
        end
        S_SHIFT: begin
          if (tick) begin
            if (!sclk_q) begin
              sclk_q <= 1'b1;
            end else begin
              sclk_q <= 1'b0;
              if (last_bit) begin
                if (pkt_left == '0) begin
                  state <= S_GAP;
                  gcnt  <= '0;
                end else if (buf_full) begin
                  pkt_left <= pkt_left - 1'b1;
                end else begin
                  state <= S_STALL;
                  err_q <= 1'b1;
                end
              end
            end
          end
        end
        S_GAP: begin
          if (gcnt == gap_lim - 1'b1) begin
            state <= S_RECOV;
            rcnt  <= '0;
          end else begin
            gcnt <= gcnt + 1'b1;
          end
        end
        S_RECOV: begin
          if (rcnt == RCNT_W'(RECOV_CYC - 1)) begin
            state <= S_IDLE;
          end else begin
            rcnt <= rcnt + 1'b1;
          end
        end
        default: state <= S_IDLE;
      endcase
      if (take) begin
        fetch_left <= fetch_left - 1'b1;
      end
    end
  end

  assign ready_o     = (state == S_IDLE);
  assign sclk_o      = sclk_q;
  assign stall_err_o = err_q;
endmodule

// File: rtl/ledchain_tx_chk.sv
module ledchain_tx_chk #(
  parameter int CNT_W = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             start_i,
  input logic             ready_o,
  input logic [CNT_W-1:0] dev_count_i,
  input logic             pkt_ready_o,
  input logic             sclk_o,
  input logic             sdat_o,
  input logic             stall_err_o
);
  // R5: data is held steady for as long as the clock stays high
  a_r5_data_stable_high: assert property (@(posedge clk) disable iff (rst)
    (sclk_o && $past(sclk_o)) |-> $stable(sdat_o));

  // R7: an idle block keeps the shift clock low
  a_r7_clk_low_idle: assert property (@(posedge clk) disable iff (rst)
    ready_o |-> !sclk_o);

  // R8: an accepted start with a non-zero count drops ready
  a_r8_ready_drops: assert property (@(posedge clk) disable iff (rst)
    (ready_o && start_i && (dev_count_i != '0)) |=> !ready_o);

  // R9: no packet is requested while idle
  a_r9_no_fetch_idle: assert property (@(posedge clk) disable iff (rst)
    ready_o |-> !pkt_ready_o);

  // R10: the error flag only changes when a frame is active or starting
  a_r10_err_held_idle: assert property (@(posedge clk) disable iff (rst)
    (ready_o && $past(ready_o) && !$past(start_i)) |-> $stable(stall_err_o));
endmodule

bind ledchain_tx ledchain_tx_chk #(.CNT_W(CNT_W)) chk_i (
  .clk         (clk),
  .rst         (rst),
  .start_i     (start_i),
  .ready_o     (ready_o),
  .dev_count_i (dev_count_i),
  .pkt_ready_o (pkt_ready_o),
  .sclk_o      (sclk_o),
  .sdat_o      (sdat_o),
  .stall_err_o (stall_err_o)
);

// File: tb/ledchain_tx_tb.sv
`timescale 1ns/1ps
module ledchain_tx_tb_top;
  localparam int PKT_W = 224;
  localparam int CNT_W = 4;
  localparam int DIV_W = 8;
  localparam int RECOV = 30;
  localparam int RXMAX = 896;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             start_i = 1'b0;
  logic [CNT_W-1:0] dev_count_i = '0;
  logic [DIV_W-1:0] half_div_i = '0;
  logic [PKT_W-1:0] pkt_data_i = '0;
  logic             pkt_valid_i = 1'b0;
  logic             ready_o, pkt_ready_o, sclk_o, sdat_o, stall_err_o;

  always #2.5 clk = ~clk;

  ledchain_tx #(.PKT_W(PKT_W), .CNT_W(CNT_W), .DIV_W(DIV_W), .GAP_BITS(9),
                .RECOV_CYC(RECOV)) dut_i (
    .clk(clk), .rst(rst), .start_i(start_i), .ready_o(ready_o),
    .dev_count_i(dev_count_i), .half_div_i(half_div_i),
    .pkt_data_i(pkt_data_i), .pkt_valid_i(pkt_valid_i),
    .pkt_ready_o(pkt_ready_o), .sclk_o(sclk_o), .sdat_o(sdat_o),
    .stall_err_o(stall_err_o));

  int n_tests = 0;
  int n_fail  = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Monitor, sampling on the falling edge of the system clock.
  int   mon_cyc = 0, mon_run = 0, rises = 0, last_rise = 0;
  int   hi_bad = 0, lo_bad = 0, lo_long = 0, dchg_bad = 0, exp_h = 2;
  bit   mon_stall = 0;
  logic prev_sclk = 1'b0, prev_sdat = 1'b0;
  logic rx [0:RXMAX-1];

  always @(negedge clk) begin
    mon_cyc++;
    if (sclk_o !== prev_sclk) begin
      if (prev_sclk) begin
        if (mon_run != exp_h) hi_bad++;
      end else begin
        if (rises > 0 && mon_run != exp_h) begin
          if (mon_stall && mon_run > exp_h) lo_long++;
          else lo_bad++;
        end
        if (rises < RXMAX) rx[rises] = sdat_o;
        rises++;
        last_rise = mon_cyc;
      end
      mon_run = 1;
    end else begin
      mon_run++;
    end
    if (sclk_o && prev_sclk && (sdat_o !== prev_sdat)) dchg_bad++;
    prev_sclk = sclk_o;
    prev_sdat = sdat_o;
  end

  function automatic logic [PKT_W-1:0] mk_raw(input int seed, input int p);
    logic [PKT_W-1:0] v;
    for (int i = 0; i < 7; i++)
      v[i*32 +: 32] = (32'(seed) * 32'h2545F491) ^ (32'(i + 8*p + 1) * 32'h9E3779B9);
    v[PKT_W-1 -: 6] = 6'b011010;
    return v;
  endfunction

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic run_frame(input int n, input int div, input int seed,
                           input bit stall, input bit poke);
    logic [PKT_W-1:0] exp_pkts [0:3];
    int  extra = 0, bad_cmd = 0, bad_dat = 0, rdy_cyc, gap, g_exp;
    logic r;
    exp_h = (div < 2) ? 2 : div;
    mon_stall = stall;
    rises = 0; hi_bad = 0; lo_bad = 0; lo_long = 0; dchg_bad = 0;
    dev_count_i = CNT_W'(n);
    half_div_i  = DIV_W'(div);
    start_i = 1'b1;
    step();
    start_i = 1'b0;
    chk(ready_o == 1'b0, "R8 ready low after start", int'(ready_o), 0);
    for (int p = 0; p < n; p++) begin
      if (stall && p == 1) repeat (2500) step();
      exp_pkts[p] = mk_raw(seed, p);
      pkt_data_i  = exp_pkts[p];
      pkt_valid_i = 1'b1;
      forever begin
        r = pkt_ready_o;
        step();
        if (r) break;
      end
      pkt_valid_i = 1'b0;
    end
    if (poke) begin
      dev_count_i = CNT_W'(3);
      half_div_i  = DIV_W'(5);
      start_i = 1'b1;
      step();
      start_i = 1'b0;
    end
    pkt_data_i  = '1;
    pkt_valid_i = 1'b1;
    while (!ready_o) begin
      if (pkt_ready_o) extra++;
      step();
    end
    pkt_valid_i = 1'b0;
    rdy_cyc = mon_cyc + 1;
    gap   = rdy_cyc - last_rise;
    g_exp = 19 * exp_h + RECOV;
    for (int p = 0; p < n; p++)
      for (int b = 0; b < PKT_W; b++) begin
        if (b < 6) begin
          if (rx[p*PKT_W + b] !== exp_pkts[p][PKT_W-1-b] && b >= 0)
            ; // raw top bits differ from the command by design
          if (rx[p*PKT_W + b] !== 1'(6'b100101 >> (5 - b))) bad_cmd++;
        end else if (rx[p*PKT_W + b] !== exp_pkts[p][PKT_W-1-b]) begin
          bad_dat++;
        end
      end
    chk(rises == PKT_W * n, "R2 rising edge count", rises, PKT_W * n);
    chk(bad_dat == 0, "R3 payload bit mismatches", bad_dat, 0);
    chk(bad_cmd == 0, "R4 command bit mismatches", bad_cmd, 0);
    chk(hi_bad == 0 && dchg_bad == 0, "R5 high phase length or data change", hi_bad + dchg_bad, 0);
    chk(lo_bad == 0, "R6 low phase length between bits", lo_bad, 0);
    chk(gap >= g_exp && gap <= g_exp + 2, "R7 last edge to ready", gap, g_exp);
    chk(extra == 0, "R9 packet requests beyond N", extra, 0);
    chk(lo_long == (stall ? 1 : 0), "R10 stretched low phases", lo_long, stall ? 1 : 0);
    chk(stall_err_o == stall, "R10 stall flag", int'(stall_err_o), int'(stall));
    step();
  endtask

  initial begin
    repeat (4) step();
    rst = 1'b0;
    step();
    chk(ready_o == 1'b1 && sclk_o == 1'b0 && sdat_o == 1'b0 &&
        pkt_ready_o == 1'b0 && stall_err_o == 1'b0, "R1 reset state",
        int'({ready_o, sclk_o, sdat_o, pkt_ready_o, stall_err_o}), 16);

    // R2: a zero device count is ignored
    dev_count_i = '0;
    half_div_i  = DIV_W'(2);
    start_i = 1'b1;
    step();
    start_i = 1'b0;
    repeat (10) step();
    chk(ready_o == 1'b1 && rises == 0 && pkt_ready_o == 1'b0,
        "R2 zero count ignored", int'(ready_o), 1);

    for (int d = 2; d <= 3; d++)
      for (int n = 1; n <= 3; n++)
        run_frame(n, d, 10 * d + n, 1'b0, (d == 3 && n == 1));
    run_frame(1, 0, 77, 1'b0, 1'b0);   // R5 divisor clamp
    run_frame(1, 1, 78, 1'b0, 1'b0);   // R5 divisor clamp
    run_frame(2, 2, 91, 1'b1, 1'b0);   // R10 mid-frame underflow
    run_frame(1, 2, 92, 1'b0, 1'b0);   // R10 flag cleared by next start

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    n_tests++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule